// File: doc/BRIEF.md
# Parallel NOR Memory Bus Front End

This block is the device side of a parallel NOR-style memory port with a 16-bit data bus. It samples the active-low pins for chip select, output enable, write enable, address valid and pin reset, along with an optional bus clock. All of these pass through two-flop synchronizers into a fast internal sample clock. From the synchronized pins it decodes one of five bus operations. It drives the data bus and the WAIT pin through separate value and enable outputs, so a pad ring can build the tri-state buffers.

An address latch takes the address in one of two ways. In asynchronous mode it is transparent while address-valid is low and holds its value once address-valid rises. In synchronous mode it captures the address on the first bus-clock rise seen with address-valid low, or on the address-valid rise, whichever comes first. A write is committed on the first rising edge of write enable or chip select. The block then issues a one-cycle strobe that carries the latched address and the data, and a small internal storage array takes that strobe. Reads return the stored word at the latched address. The mode input is a static configuration and may change only while the bus is idle.

Top module: `pflash_bus_front`

## Requirements
- R1: `op_o` reports the decoded operation with this encoding and priority. Pin reset low gives 4 (reset). Otherwise chip select high gives 3 (standby). Otherwise write enable low with output enable high gives 1 (write). Otherwise output enable low with write enable high gives 0 (read). Every other case, including output enable and write enable both low, gives 2 (output disable).
- R2: During a read, `dq_oe_o` is 1 and `dq_o` carries the stored word at the latched address.
- R3: `dq_oe_o` is 0 in every operation other than read. `wait_oe_o` is 1 only during a read in synchronous mode, and `wait_o` is 0 (ready) at those times.
- R4: A write ends with exactly one single-cycle `wr_stb_o` pulse. The pulse comes on the first rise of write enable or chip select, whichever is first. It carries the latched address on `wr_addr_o` and the bus data on `wr_data_o`, and that data lands in storage.
- R5: If pin reset goes low during a write, the write produces no strobe and leaves storage unchanged.
- R6: In asynchronous mode the latch follows `addr_i` while address-valid is low. After address-valid rises, later changes to `addr_i` have no effect.
- R7: In synchronous mode, the first bus-clock rise with address-valid low captures the address. Later address changes in that same address-valid low phase are ignored.
- R8: In synchronous mode with no bus-clock rise, the rise of address-valid captures the address that was present just before it.
- R9: `blk_o` gives the upper `BLK_BITS` bits of the latched address, which form the block select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | fast internal sample clock |
| rst_ni | input | 1 | system reset, active low, asynchronous |
| sync_mode_i | input | 1 | 1 selects synchronous address capture (static) |
| bclk_i | input | 1 | bus clock pin |
| cs_ni | input | 1 | chip select pin, active low |
| oe_ni | input | 1 | output enable pin, active low |
| we_ni | input | 1 | write enable pin, active low |
| av_ni | input | 1 | address valid pin, active low |
| prst_ni | input | 1 | device reset pin, active low |
| addr_i | input | AW | address pins |
| dq_i | input | DW | data bus as seen at the pad input |
| dq_o | output | DW | data bus drive value |
| dq_oe_o | output | 1 | data bus drive enable |
| wait_o | output | 1 | WAIT drive value (0 = ready) |
| wait_oe_o | output | 1 | WAIT drive enable |
| op_o | output | 3 | decoded bus operation |
| blk_o | output | BLK_BITS | block select from the latched address |
| wr_stb_o | output | 1 | one-cycle write commit strobe |
| wr_addr_o | output | AW | address committed by the write |
| wr_data_o | output | DW | data committed by the write |

## Verification
A pin change reaches the synchronized view after two sample edges. `op_o`, `dq_oe_o`, `wait_oe_o` and the latch follow one edge later. `dq_o` follows one edge after that, and a write strobe appears three edges after the terminating pin rise. The bench holds every pin phase for at least three cycles. It checks static results six cycles after the last pin change, on the falling clock edge. It counts strobes with a monitor that runs every cycle, so a missing or doubled strobe shows up however late it comes.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_ODIS  = 3'd2,
        OP_STBY  = 3'd3,
        OP_RST   = 3'd4
    } op_e;

    typedef struct packed {
        logic bclk;
        logic av_n;
        logic we_n;
        logic oe_n;
        logic cs_n;
        logic prst_n;
    } pins_t;

    localparam int unsigned PINS_W = 6;
    localparam pins_t PINS_IDLE = '{bclk: 1'b0, av_n: 1'b1, we_n: 1'b1,
                                    oe_n: 1'b1, cs_n: 1'b1, prst_n: 1'b0};

    function automatic op_e decode_op(pins_t p);
        if (!p.prst_n)               return OP_RST;
        else if (p.cs_n)             return OP_STBY;
        else if (!p.we_n && p.oe_n)  return OP_WRITE;
        else if (!p.oe_n && p.we_n)  return OP_READ;
        else                         return OP_ODIS;
    endfunction

endpackage

// File: rtl/pfb_sync.sv
module pfb_sync #(
    parameter int unsigned W = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t d, q;

    always_comb begin
        d    = q;
        d.s1 = d_i;
        d.s2 = q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{s1: RST_VAL, s2: RST_VAL};
        else         q <= d;
    end

    assign q_o = q.s2;
endmodule

// File: rtl/pfb_addr_latch.sv
module pfb_addr_latch #(
    parameter int unsigned AW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          sync_mode_i,
    input  logic          run_i,
    input  logic          av_n_i,
    input  logic          av_n_prev_i,
    input  logic          bclk_i,
    input  logic          bclk_prev_i,
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] addr_prev_i,
    output logic [AW-1:0] lat_o
);
    typedef struct packed {
        logic [AW-1:0] lat;
        logic          done;
    } st_t;

    st_t d, q;
    logic clk_rise;
    logic av_rise;

    assign clk_rise = bclk_i && !bclk_prev_i;
    assign av_rise  = av_n_i && !av_n_prev_i;

    always_comb begin
        d = q;
        if (!run_i) begin
            d.lat  = '0;
            d.done = 1'b0;
        end else if (!sync_mode_i) begin
            if (!av_n_i) d.lat = addr_i;
            d.done = 1'b0;
        end else if (!av_n_i) begin
            if (clk_rise && !q.done) begin
                d.lat  = addr_i;
                d.done = 1'b1;
            end
        end else begin
            if (av_rise && !q.done) d.lat = addr_prev_i;
            d.done = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign lat_o = q.lat;
endmodule

// File: rtl/pfb_store.sv
module pfb_store #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 16
) (
    input  logic          clk_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pflash_bus_front.sv
module pflash_bus_front
    import pfb_pkg::*;
#(
    parameter int unsigned AW       = 8,
    parameter int unsigned DW       = 16,
    parameter int unsigned BLK_BITS = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                sync_mode_i,
    input  logic                bclk_i,
    input  logic                cs_ni,
    input  logic                oe_ni,
    input  logic                we_ni,
    input  logic                av_ni,
    input  logic                prst_ni,
    input  logic [AW-1:0]       addr_i,
    input  logic [DW-1:0]       dq_i,
    output logic [DW-1:0]       dq_o,
    output logic                dq_oe_o,
    output logic                wait_o,
    output logic                wait_oe_o,
    output logic [2:0]          op_o,
    output logic [BLK_BITS-1:0] blk_o,
    output logic                wr_stb_o,
    output logic [AW-1:0]       wr_addr_o,
    output logic [DW-1:0]       wr_data_o
);
    localparam int unsigned SW = PINS_W + AW + DW;
    localparam logic [SW-1:0] SYNC_RST = {PINS_IDLE, {(AW + DW){1'b0}}};

    typedef struct packed {
        op_e           op;
        logic          av_p;
        logic          bclk_p;
        logic [AW-1:0] addr_p;
        logic [DW-1:0] dq_p;
        logic [DW-1:0] rdata;
        logic          dq_oe;
        logic          wait_oe;
        logic          wait_v;
        logic          stb;
        logic [AW-1:0] waddr;
        logic [DW-1:0] wdata;
    } st_t;

    st_t d, q;

    logic [SW-1:0] raw_vec, syn_vec;
    pins_t         pins_s;
    logic [AW-1:0] addr_s;
    logic [DW-1:0] dq_s;
    logic [AW-1:0] lat;
    logic [DW-1:0] rd_data;
    op_e           op_now;

    assign raw_vec = {bclk_i, av_ni, we_ni, oe_ni, cs_ni, prst_ni, addr_i, dq_i};

    pfb_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (raw_vec),
        .q_o   (syn_vec)
    );

    assign pins_s = pins_t'(syn_vec[SW-1 -: PINS_W]);
    assign addr_s = syn_vec[DW +: AW];
    assign dq_s   = syn_vec[DW-1:0];
    assign op_now = decode_op(pins_s);

    pfb_addr_latch #(.AW(AW)) u_latch (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sync_mode_i(sync_mode_i),
        .run_i      (pins_s.prst_n),
        .av_n_i     (pins_s.av_n),
        .av_n_prev_i(q.av_p),
        .bclk_i     (pins_s.bclk),
        .bclk_prev_i(q.bclk_p),
        .addr_i     (addr_s),
        .addr_prev_i(q.addr_p),
        .lat_o      (lat)
    );

    pfb_store #(.AW(AW), .DW(DW)) u_store (
        .clk_i  (clk_i),
        .we_i   (q.stb),
        .waddr_i(q.waddr),
        .wdata_i(q.wdata),
        .raddr_i(lat),
        .rdata_o(rd_data)
    );

    always_comb begin
        d         = q;
        d.op      = op_now;
        d.av_p    = pins_s.av_n;
        d.bclk_p  = pins_s.bclk;
        d.addr_p  = addr_s;
        d.dq_p    = dq_s;
        d.rdata   = rd_data;
        d.dq_oe   = (op_now == OP_READ);
        d.wait_oe = sync_mode_i && (op_now == OP_READ);
        d.wait_v  = !d.wait_oe;
        // commit on the first of the two terminating rises
        d.stb     = (q.op == OP_WRITE) && pins_s.prst_n
                    && (pins_s.we_n || pins_s.cs_n);
        d.waddr   = lat;
        d.wdata   = q.dq_p;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q        <= '0;
            q.op     <= OP_RST;
            q.av_p   <= 1'b1;
            q.wait_v <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign dq_o      = q.rdata;
    assign dq_oe_o   = q.dq_oe;
    assign wait_o    = q.wait_v;
    assign wait_oe_o = q.wait_oe;
    assign op_o      = q.op;
    assign blk_o     = lat[AW-1 -: BLK_BITS];
    assign wr_stb_o  = q.stb;
    assign wr_addr_o = q.waddr;
    assign wr_data_o = q.wdata;
endmodule

// File: rtl/pfb_checker.sv
module pfb_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       sync_mode_i,
    input logic [2:0] op_o,
    input logic       dq_oe_o,
    input logic       wait_o,
    input logic       wait_oe_o,
    input logic       wr_stb_o
);
    a_r3_dq_drive_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dq_oe_o |-> op_o == 3'd0);

    a_r3_wait_sync_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wait_oe_o |-> (sync_mode_i && op_o == 3'd0 && !wait_o));

    a_r1_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_o == 3'd4 |-> (!dq_oe_o && !wait_oe_o));

    a_r4_stb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_stb_o |=> !wr_stb_o);

    a_r4_stb_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_stb_o |-> $past(op_o) == 3'd1);

    a_r5_no_stb_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_stb_o |-> op_o != 3'd4);
endmodule

bind pflash_bus_front pfb_checker u_pfb_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_mode_i(sync_mode_i),
    .op_o       (op_o),
    .dq_oe_o    (dq_oe_o),
    .wait_o     (wait_o),
    .wait_oe_o  (wait_oe_o),
    .wr_stb_o   (wr_stb_o)
);

// File: tb/test_pflash_bus_front.sv
`timescale 1ns/1ps
module test_pflash_bus_front;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int BB = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_mode = 1'b0;
    logic bclk = 1'b0, cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, av_n = 1'b1, prst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_o;
    logic dq_oe, wait_v, wait_oe, wr_stb;
    logic [2:0] op;
    logic [BB-1:0] blk;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    always #5 clk = ~clk;

    pflash_bus_front #(.AW(AW), .DW(DW), .BLK_BITS(BB)) i_pflash_bus_front (
        .clk_i(clk), .rst_ni(rst_n), .sync_mode_i(sync_mode), .bclk_i(bclk),
        .cs_ni(cs_n), .oe_ni(oe_n), .we_ni(we_n), .av_ni(av_n), .prst_ni(prst_n),
        .addr_i(addr), .dq_i(dq_in), .dq_o(dq_o), .dq_oe_o(dq_oe),
        .wait_o(wait_v), .wait_oe_o(wait_oe), .op_o(op), .blk_o(blk),
        .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
    );

    int n_chk = 0, n_bad = 0, stb_cnt = 0;
    bit finished = 1'b0;
    logic [AW-1:0] last_addr;
    logic [DW-1:0] last_data;
    logic [DW-1:0] model [1<<AW];
    bit valid [1<<AW];

    always @(negedge clk) begin
        if (wr_stb) begin
            stb_cnt   <= stb_cnt + 1;
            last_addr <= wr_addr;
            last_data <= wr_data;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [BB-1:0] exp_blk(logic [AW-1:0] a);
        return a[AW-1 -: BB];
    endfunction

    task automatic idle();
        cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; av_n = 1'b1; bclk = 1'b0;
        cyc(4);
    endtask

    // address phase; ends with address-valid high and addr_i scrambled
    task automatic addr_phase(logic [AW-1:0] a, bit use_clk);
        cs_n = 1'b0; av_n = 1'b0; addr = a;
        cyc(3);
        if (sync_mode && use_clk) begin
            bclk = 1'b1; cyc(3); bclk = 1'b0; cyc(3);
            addr = ~a; cyc(3);           // R7: ignored after clock capture
        end
        av_n = 1'b1;
        cyc(1);
        addr = a ^ 8'h5A;                // R6/R8: ignored after address-valid rise
        cyc(3);
    endtask

    task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] v, bit cs_first, bit use_clk);
        int s0;
        s0 = stb_cnt;
        addr_phase(a, use_clk);
        dq_in = v; we_n = 1'b0;
        cyc(4);
        if (cs_first) cs_n = 1'b1; else we_n = 1'b1;
        cyc(4);
        cs_n = 1'b1; we_n = 1'b1;
        cyc(4);
        dq_in = ~v;
        chk(stb_cnt == s0 + 1, "R4 strobe count", stb_cnt, s0 + 1);
        chk(last_addr == a, "R4 write address", last_addr, a);
        chk(last_data == v, "R4 write data", last_data, v);
        model[a] = v; valid[a] = 1'b1;
        idle();
    endtask

    task automatic do_read(logic [AW-1:0] a, bit use_clk);
        addr_phase(a, use_clk);
        oe_n = 1'b0;
        cyc(6);
        chk(op == 3'd0, "R1 read code", op, 0);
        chk(dq_oe == 1'b1, "R2 drive enable", dq_oe, 1);
        chk(dq_o == model[a], use_clk ? "R7 read data" : "R2 R6 R8 read data", dq_o, model[a]);
        chk(blk == exp_blk(a), "R9 block select", blk, exp_blk(a));
        chk(wait_oe == sync_mode, "R3 wait enable", wait_oe, sync_mode);
        if (sync_mode) chk(wait_v == 1'b0, "R3 wait ready", wait_v, 0);
        oe_n = 1'b1;
        cyc(6);
        chk(op == 3'd2, "R1 output disable code", op, 2);
        chk(dq_oe == 1'b0 && wait_oe == 1'b0, "R3 disabled drive", {dq_oe, wait_oe}, 0);
        idle();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        cyc(4);
        rst_n = 1'b1;
        cyc(6);
        chk(op == 3'd4, "R1 reset code", op, 4);
        chk(dq_oe == 0 && wait_oe == 0 && wr_stb == 0, "R3 reset quiet",
            {dq_oe, wait_oe, wr_stb}, 0);
        prst_n = 1'b1;
        cyc(6);
        chk(op == 3'd3, "R1 standby code", op, 3);

        // directed: asynchronous mode
        do_write(8'hC3, 16'hBEEF, 1'b0, 1'b0);
        do_read(8'hC3, 1'b0);
        do_write(8'h41, 16'h1234, 1'b1, 1'b0);   // chip select rises first
        do_read(8'h41, 1'b0);

        // R1: output enable and write enable both low -> output disable, no write
        begin
            int s0;
            s0 = stb_cnt;
            addr_phase(8'h41, 1'b0);
            dq_in = 16'hDEAD; oe_n = 1'b0; we_n = 1'b0;
            cyc(6);
            chk(op == 3'd2, "R1 both-low code", op, 2);
            chk(dq_oe == 1'b0, "R3 both-low no drive", dq_oe, 0);
            we_n = 1'b1; oe_n = 1'b1; cyc(6);
            chk(stb_cnt == s0, "R1 both-low no strobe", stb_cnt, s0);
            idle();
        end

        // R5: pin reset during a write
        begin
            int s0;
            s0 = stb_cnt;
            addr_phase(8'hC3, 1'b0);
            dq_in = 16'h0F0F; we_n = 1'b0;
            cyc(4);
            prst_n = 1'b0;
            cyc(6);
            chk(op == 3'd4, "R1 pin reset code", op, 4);
            we_n = 1'b1; cs_n = 1'b1;
            cyc(4);
            prst_n = 1'b1;
            cyc(6);
            chk(stb_cnt == s0, "R5 aborted write no strobe", stb_cnt, s0);
            idle();
            do_read(8'hC3, 1'b0);
        end

        // directed: synchronous mode
        sync_mode = 1'b1;
        cyc(4);
        do_write(8'h9A, 16'hA5A5, 1'b0, 1'b1);
        do_read(8'h9A, 1'b1);                    // R7 clock capture
        do_read(8'h41, 1'b0);                    // R8 address-valid capture
        do_write(8'h07, 16'h7777, 1'b1, 1'b0);
        do_read(8'h07, 1'b1);

        // constrained random
        for (int i = 0; i < 60; i++) begin
            logic [AW-1:0] a;
            bit rd;
            if ((i % 15) == 0) begin
                sync_mode = $urandom_range(0, 1);
                cyc(4);
            end
            a  = AW'($urandom_range(0, 31) * 8 + $urandom_range(0, 7));
            rd = $urandom_range(0, 1) && valid[a];
            if (rd) do_read(a, $urandom_range(0, 1));
            else    do_write(a, DW'($urandom), $urandom_range(0, 1), $urandom_range(0, 1));
        end

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        end
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        end
        $finish;
    end
endmodule